// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block is a memory-mapped timer with a parameterised number of independent channels. Each channel holds a programmable interval and a down-counter that is advanced by its own power-of-two prescaler. A channel either stops when it expires (one-shot) or reloads its interval and keeps going (periodic). One channel loaded with all ones and left periodic gives a free-running time base: inverting the count it reads gives an up-count. Another channel serves as an event timer that raises the shared interrupt line.

Software reaches the block through a simple single-cycle register port. Reads are combinational on the address while the read strobe is high. Writes take effect at the clock edge on which the write strobe is sampled. Two global registers hold an interrupt mask and sticky expiry flags that are cleared by writing ones to them. Turning a channel on or off goes through a two-stage pipeline. Software must therefore allow a few timer ticks of settling after a stop and must not program delays shorter than three ticks.

Top module: `tmr_bank_top`

## Requirements
- R1: After reset every register reads 0: the interrupt mask, the expiry flags, and every channel's control, interval and count words. The interrupt output is low.
- R2: Offset 0x00 is the interrupt mask, with bit n belonging to channel n; only the low NUM_CH bits are kept. Offset 0x04 holds the expiry flags. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R3: Channel n's registers start at 0x20·n + 0x10. At +0x00 is control: bit 0 run, bit 1 load, bits 6:4 prescaler select, bit 7 one-shot (1) or periodic (0). At +0x04 and +0x08 are the low and high interval words. At +0x0C and +0x10 are the low and high count words, read-only. Control reads back with bit 1 and every unused bit as 0.
- R4: A control write with bit 1 set copies the interval into the counter at that edge, whether or not bit 0 is set. A stopped channel's count does not move.
- R5: If control is written with run set and prescaler select p at edge E, the counter decrements at edges E+2+k·2^p for k = 1, 2, ...
- R6: If run is cleared at edge S, the counter still decrements at most at edges S+1 and S+2. It never decrements after S+2.
- R7: Expiry is a decrement tick that finds the count at 0. Expiry sets the channel's flag at that edge. In one-shot mode the count stays 0 and run reads back 0. In periodic mode the count reloads the interval, so one period is (interval+1)·2^p cycles.
- R8: The interrupt output is high exactly when some channel has both its flag and its mask bit set.
- R9: A channel with an all-ones interval running periodically yields a time base: the bitwise inverse of its low count word increases by one per tick.
- R10: Intervals from 3 up to all ones in the low word, 0xFFFFFFFF, are held and counted correctly.
- R11: Channels run independently. Running one channel does not move another channel's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the address |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with two channels, a 64-bit counter and an 8-bit address. This covers the global registers, both channel windows and the split high words. Two channels are enough to run a periodic event channel next to a stopped one and to show that their flags and mask bits stay separate. Short intervals at prescaler selects 0, 1 and 2 let the bench check the start latency, the stop latency and the exact expiry edges within a few dozen cycles. An all-ones interval covers the time-base use and the widest values.

// File: rtl/tmr_pkg.sv
`timescale 1ns/100ps
package tmr_pkg;

  localparam int REG_W           = 32;
  localparam int PRE_SEL_W       = 3;
  localparam int PRE_ACC_W       = (1 << PRE_SEL_W) - 1;
  localparam int CH_STRIDE_LOG2  = 5;
  localparam int CH_REGION_BASE  = 'h10;
  localparam int OFF_IRQ_EN      = 'h00;
  localparam int OFF_IRQ_STS     = 'h04;

  // Sub-offsets inside one channel window (relative to 0x20*n + 0x10)
  localparam logic [CH_STRIDE_LOG2-1:0] SUB_CTL    = 5'h00;
  localparam logic [CH_STRIDE_LOG2-1:0] SUB_IVL_LO = 5'h04;
  localparam logic [CH_STRIDE_LOG2-1:0] SUB_IVL_HI = 5'h08;
  localparam logic [CH_STRIDE_LOG2-1:0] SUB_CNT_LO = 5'h0C;
  localparam logic [CH_STRIDE_LOG2-1:0] SUB_CNT_HI = 5'h10;

  // Control word bit positions
  localparam int CTL_RUN_BIT     = 0;
  localparam int CTL_LOAD_BIT    = 1;
  localparam int CTL_PRE_LSB     = 4;
  localparam int CTL_ONESHOT_BIT = 7;

  typedef struct packed {
    logic                 one_shot;
    logic [PRE_SEL_W-1:0] pre_sel;
    logic                 run;
  } tmr_ctl_t;

  function automatic tmr_ctl_t ctl_unpack(input logic [REG_W-1:0] w);
    tmr_ctl_t c;
    c.one_shot = w[CTL_ONESHOT_BIT];
    c.pre_sel  = w[CTL_PRE_LSB +: PRE_SEL_W];
    c.run      = w[CTL_RUN_BIT];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] ctl_pack(input tmr_ctl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[CTL_ONESHOT_BIT]             = c.one_shot;
    w[CTL_PRE_LSB +: PRE_SEL_W]    = c.pre_sel;
    w[CTL_RUN_BIT]                 = c.run;
    return w;
  endfunction

  // Terminal value of the prescaler accumulator: 2^sel - 1
  function automatic logic [PRE_ACC_W-1:0] pre_limit(input logic [PRE_SEL_W-1:0] sel);
    logic [PRE_ACC_W:0] span;
    span = ({{PRE_ACC_W{1'b0}}, 1'b1} << sel) - {{PRE_ACC_W{1'b0}}, 1'b1};
    return span[PRE_ACC_W-1:0];
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/100ps
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [PRE_SEL_W-1:0] sel,
  output logic                 tick
);

  logic [PRE_ACC_W-1:0] acc_q;
  logic                 at_limit;

  assign at_limit = (acc_q == pre_limit(sel));
  assign tick     = run && at_limit;

  always_ff @(posedge clk) begin
    if (!rst_n)                 acc_q <= '0;
    else if (!run || at_limit)  acc_q <= '0;
    else                        acc_q <= acc_q + 1'b1;
  end

  // R5: with a divider above one, ticks never come on back-to-back cycles
  assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != '0) |=> (!tick || sel == '0));

endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/100ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 64
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ivl_lo_we,
  input  logic             ivl_hi_we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctl_word,
  output logic [CNT_W-1:0] ivl_val,
  output logic [CNT_W-1:0] cnt_val,
  output logic             expire
);

  localparam int HI_W = CNT_W - REG_W;

  tmr_ctl_t         ctl_q;
  tmr_ctl_t         ctl_wr;
  logic             run_s1, run_s2;
  logic [CNT_W-1:0] ivl_q, cnt_q;
  logic             tick;
  logic             load_req;
  logic             halt_oneshot;

  // Next counter value for one tick: decrement, or at zero reload/hold
  function automatic logic [CNT_W-1:0] count_step(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] ivl,
    input logic             step,
    input logic             periodic
  );
    if (!step)        return cur;
    if (cur == '0)    return periodic ? ivl : cur;
    return cur - CNT_W'(1);
  endfunction

  assign ctl_wr       = ctl_unpack(wdata);
  assign load_req     = ctl_we && wdata[CTL_LOAD_BIT];
  assign expire       = tick && (cnt_q == '0);
  assign halt_oneshot = expire && ctl_q.one_shot;

  tmr_prescaler u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_s2),
    .sel   (ctl_q.pre_sel),
    .tick  (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      run_s1 <= 1'b0;
      run_s2 <= 1'b0;
      ivl_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (ctl_we)            ctl_q     <= ctl_wr;
      else if (halt_oneshot) ctl_q.run <= 1'b0;

      if (halt_oneshot) begin
        run_s1 <= 1'b0;
        run_s2 <= 1'b0;
      end else begin
        run_s1 <= ctl_q.run;
        run_s2 <= run_s1;
      end

      if (ivl_lo_we) ivl_q[REG_W-1:0]     <= wdata;
      if (ivl_hi_we) ivl_q[CNT_W-1:REG_W] <= wdata[HI_W-1:0];

      if (load_req) cnt_q <= ivl_q;
      else          cnt_q <= count_step(cnt_q, ivl_q, tick, !ctl_q.one_shot);
    end
  end

  assign ctl_word = ctl_pack(ctl_q);
  assign ivl_val  = ivl_q;
  assign cnt_val  = cnt_q;

  // R6: run low for three cycles in a row freezes the count
  assert_stop_settled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_req && !ctl_q.run && !$past(ctl_q.run) && !$past(ctl_q.run, 2))
      |=> (cnt_q == $past(cnt_q)));

  // R5: outside a load the count only steps down by one or reloads
  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q) && !$past(load_req))
      |-> (cnt_q == $past(cnt_q) - CNT_W'(1) || cnt_q == $past(ivl_q)));

  // R7: one-shot expiry halts the channel at zero
  assert_oneshot_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctl_q.one_shot && !ctl_we) |=> (!ctl_q.run && cnt_q == '0));

  // R7: periodic expiry restarts from the interval
  assert_periodic_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctl_q.one_shot && !ctl_we) |=> (cnt_q == $past(ivl_q)));

endmodule

// File: rtl/tmr_irq_ctrl.sv
`timescale 1ns/100ps
module tmr_irq_ctrl
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_we,
  input  logic              sts_we,
  input  logic [REG_W-1:0]  wdata,
  input  logic [NUM_CH-1:0] expire,
  output logic [NUM_CH-1:0] irq_en,
  output logic [NUM_CH-1:0] status,
  output logic              irq
);

  logic [NUM_CH-1:0] clr_mask;

  assign clr_mask = sts_we ? wdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en <= '0;
      status <= '0;
    end else begin
      if (en_we) irq_en <= wdata[NUM_CH-1:0];
      status <= (status & ~clr_mask) | expire;
    end
  end

  assign irq = |(status & irq_en);

  // R7: every expiry leaves its flag set on the next cycle
  assert_flag_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|expire) |=> ((status & $past(expire)) == $past(expire)));

  // R2: written ones clear their flags unless the channel expired again
  assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sts_we |=> ((status & $past(wdata[NUM_CH-1:0]) & ~$past(expire)) == '0));

  // R8: the request only rises after an expiry or a mask change
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|expire) || $past(en_we)));

endmodule

// File: rtl/tmr_bank_top.sv
`timescale 1ns/100ps
module tmr_bank_top
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 64,
  parameter int ADDR_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq
);

  localparam int SEL_W = ADDR_W - CH_STRIDE_LOG2;

  logic [ADDR_W-1:0]         rel_addr;
  logic [SEL_W-1:0]          sel_ch;
  logic [CH_STRIDE_LOG2-1:0] sub_off;
  logic                      in_ch_space;
  logic [NUM_CH-1:0]         ch_hit;
  logic [NUM_CH-1:0]         ch_expire;
  logic [NUM_CH-1:0]         irq_en;
  logic [NUM_CH-1:0]         irq_sts;
  logic [REG_W-1:0]          ch_ctl [NUM_CH];
  logic [CNT_W-1:0]          ch_ivl [NUM_CH];
  logic [CNT_W-1:0]          ch_cnt [NUM_CH];
  logic                      en_we, sts_we;
  logic [REG_W-1:0]          rd_mux;

  // Address decode: global words below the channel region, then one window per channel
  assign in_ch_space = (bus_addr >= ADDR_W'(CH_REGION_BASE));
  assign rel_addr    = bus_addr - ADDR_W'(CH_REGION_BASE);
  assign sel_ch      = rel_addr[ADDR_W-1:CH_STRIDE_LOG2];
  assign sub_off     = rel_addr[CH_STRIDE_LOG2-1:0];
  assign en_we       = bus_wr && (bus_addr == ADDR_W'(OFF_IRQ_EN));
  assign sts_we      = bus_wr && (bus_addr == ADDR_W'(OFF_IRQ_STS));

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      assign ch_hit[g] = in_ch_space && (sel_ch == SEL_W'(g));

      tmr_channel #(.CNT_W(CNT_W)) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (bus_wr && ch_hit[g] && sub_off == SUB_CTL),
        .ivl_lo_we (bus_wr && ch_hit[g] && sub_off == SUB_IVL_LO),
        .ivl_hi_we (bus_wr && ch_hit[g] && sub_off == SUB_IVL_HI),
        .wdata     (bus_wdata),
        .ctl_word  (ch_ctl[g]),
        .ivl_val   (ch_ivl[g]),
        .cnt_val   (ch_cnt[g]),
        .expire    (ch_expire[g])
      );
    end
  endgenerate

  tmr_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_we  (en_we),
    .sts_we (sts_we),
    .wdata  (bus_wdata),
    .expire (ch_expire),
    .irq_en (irq_en),
    .status (irq_sts),
    .irq    (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFF_IRQ_EN))  rd_mux = REG_W'(irq_en);
    if (bus_addr == ADDR_W'(OFF_IRQ_STS)) rd_mux = REG_W'(irq_sts);
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_hit[i]) begin
        case (sub_off)
          SUB_CTL:    rd_mux = ch_ctl[i];
          SUB_IVL_LO: rd_mux = ch_ivl[i][REG_W-1:0];
          SUB_IVL_HI: rd_mux = REG_W'(ch_ivl[i][CNT_W-1:REG_W]);
          SUB_CNT_LO: rd_mux = ch_cnt[i][REG_W-1:0];
          SUB_CNT_HI: rd_mux = REG_W'(ch_cnt[i][CNT_W-1:REG_W]);
          default:    ;
        endcase
      end
    end
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;

  // R3: a channel window is selected by at most one decoder output
  assert_single_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_hit));

endmodule

// File: tb/tb_tmr_bank_top.sv
`timescale 1ns/100ps
module tb_tmr_bank_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 1'b0;

  always #2 clk = ~clk;

  tmr_bank_top #(.NUM_CH(2), .CNT_W(64), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Register addresses derived from the channel window layout
  function automatic logic [7:0] ch_addr(input int ch, input int sub);
    return 8'(32 * ch + 16 + sub);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #0.1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, {32'h0, d}, {32'h0, exp});
  endtask

  task automatic skip(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rdchk("R1 irq mask", 8'h00, 32'h0);
    rdchk("R1 flags", 8'h04, 32'h0);
    rdchk("R1 ch0 control", ch_addr(0, 0), 32'h0);
    rdchk("R1 ch0 count lo", ch_addr(0, 'hC), 32'h0);
    rdchk("R1 ch1 interval hi", ch_addr(1, 8), 32'h0);
    check("R1 irq low", {63'h0, irq}, 64'h0);
  endtask

  task automatic t_regmap;
    wr(8'h00, 32'hFFFF_FFFF);
    rdchk("R2 mask keeps NUM_CH bits", 8'h00, 32'h3);
    wr(8'h00, 32'h0);
    wr(ch_addr(0, 4), 32'h1234_5678);
    wr(ch_addr(0, 8), 32'h0000_0009);
    rdchk("R3 interval hi", ch_addr(0, 8), 32'h9);
    wr(ch_addr(0, 0), 32'h0000_00F6);          // load set, run clear
    rdchk("R3 control readback", ch_addr(0, 0), 32'hF0);
    rdchk("R4 load without run lo", ch_addr(0, 'hC), 32'h1234_5678);
    rdchk("R4 load without run hi", ch_addr(0, 'h10), 32'h9);
    skip(5);
    rdchk("R4 stopped count frozen", ch_addr(0, 'hC), 32'h1234_5678);
    wr(ch_addr(0, 0), 32'h0);
  endtask

  task automatic t_start_stop;
    wr(ch_addr(0, 4), 32'd1000);
    wr(ch_addr(0, 8), 32'd0);
    wr(ch_addr(0, 0), 32'h03);                  // edge E, p = 0
    rdchk("R4 load on start", ch_addr(0, 'hC), 32'd1000);
    skip(2);
    rdchk("R5 no step before E+3", ch_addr(0, 'hC), 32'd1000);
    skip(1);
    rdchk("R5 first step at E+3", ch_addr(0, 'hC), 32'd999);
    skip(7);
    rdchk("R5 count at E+10", ch_addr(0, 'hC), 32'd992);
    wr(ch_addr(0, 0), 32'h00);                  // edge S = E+11
    rdchk("R6 count at S", ch_addr(0, 'hC), 32'd991);
    skip(1);
    rdchk("R6 step at S+1", ch_addr(0, 'hC), 32'd990);
    skip(1);
    rdchk("R6 step at S+2", ch_addr(0, 'hC), 32'd989);
    skip(4);
    rdchk("R6 frozen after S+2", ch_addr(0, 'hC), 32'd989);
  endtask

  task automatic t_prescale;
    wr(ch_addr(0, 0), 32'h23);                  // edge E, p = 2
    rdchk("R4 reload restarts count", ch_addr(0, 'hC), 32'd1000);
    skip(5);
    rdchk("R5 p=2 no step at E+5", ch_addr(0, 'hC), 32'd1000);
    skip(1);
    rdchk("R5 p=2 step at E+6", ch_addr(0, 'hC), 32'd999);
    skip(3);
    rdchk("R5 p=2 hold at E+9", ch_addr(0, 'hC), 32'd999);
    skip(1);
    rdchk("R5 p=2 step at E+10", ch_addr(0, 'hC), 32'd998);
    wr(ch_addr(0, 0), 32'h00);
    skip(4);
  endtask

  task automatic t_oneshot;
    logic [31:0] d;
    wr(8'h00, 32'h1);
    wr(ch_addr(0, 4), 32'd3);                   // smallest delay
    wr(ch_addr(0, 0), 32'h83);                  // edge E, one-shot, p = 0
    rdchk("R10 minimum interval loaded", ch_addr(0, 'hC), 32'd3);
    skip(5);
    rdchk("R7 count zero at E+5", ch_addr(0, 'hC), 32'd0);
    rdchk("R7 no flag before expiry", 8'h04, 32'h0);
    check("R8 irq low before expiry", {63'h0, irq}, 64'h0);
    skip(1);
    rdchk("R7 flag at expiry", 8'h04, 32'h1);
    check("R8 irq high on masked-in flag", {63'h0, irq}, 64'h1);
    rdchk("R7 one-shot clears run", ch_addr(0, 0), 32'h80);
    skip(3);
    rdchk("R7 one-shot holds zero", ch_addr(0, 'hC), 32'd0);
    rd(8'h04, d);
    check("R7 flag sticky", {32'h0, d}, 64'h1);
    wr(8'h04, 32'h0);
    rdchk("R2 writing zero keeps flag", 8'h04, 32'h1);
    wr(8'h04, 32'h1);
    rdchk("R2 write-one clears flag", 8'h04, 32'h0);
    check("R8 irq low after clear", {63'h0, irq}, 64'h0);
  endtask

  task automatic t_periodic;
    wr(8'h00, 32'h0);
    wr(ch_addr(1, 4), 32'd4);
    wr(ch_addr(1, 8), 32'd0);
    wr(ch_addr(1, 0), 32'h13);                  // edge E, periodic, p = 1
    rdchk("R4 ch1 loaded", ch_addr(1, 'hC), 32'd4);
    skip(11);
    rdchk("R7 ch1 zero at E+11", ch_addr(1, 'hC), 32'd0);
    rdchk("R7 no flag at E+11", 8'h04, 32'h0);
    skip(1);
    rdchk("R7 periodic reload at E+12", ch_addr(1, 'hC), 32'd4);
    rdchk("R7 ch1 flag at E+12", 8'h04, 32'h2);
    check("R8 masked flag keeps irq low", {63'h0, irq}, 64'h0);
    skip(2);
    rdchk("R7 ch1 counting again", ch_addr(1, 'hC), 32'd3);
    skip(8);
    rdchk("R7 second period at E+22", ch_addr(1, 'hC), 32'd4);
    rdchk("R11 ch0 untouched", ch_addr(0, 'hC), 32'd0);
    wr(8'h00, 32'h2);
    check("R8 irq after unmask", {63'h0, irq}, 64'h1);
    wr(8'h04, 32'h2);
    rdchk("R2 ch1 flag cleared", 8'h04, 32'h0);
    check("R8 irq low after ch1 clear", {63'h0, irq}, 64'h0);
    wr(ch_addr(1, 0), 32'h00);
    skip(4);
  endtask

  task automatic t_timebase;
    logic [31:0] d;
    wr(ch_addr(0, 4), 32'hFFFF_FFFF);
    wr(ch_addr(0, 8), 32'hFFFF_FFFF);
    wr(ch_addr(0, 0), 32'h03);                  // edge E
    rd(ch_addr(0, 'hC), d);
    check("R9 up-count starts at 0", {32'h0, ~d}, 64'd0);
    skip(5);
    rd(ch_addr(0, 'hC), d);
    check("R9 up-count at E+5", {32'h0, ~d}, 64'd3);
    skip(15);
    rd(ch_addr(0, 'hC), d);
    check("R9 up-count at E+20", {32'h0, ~d}, 64'd18);
    rdchk("R10 count hi all ones", ch_addr(0, 'h10), 32'hFFFF_FFFF);
    rdchk("R10 interval lo max", ch_addr(0, 4), 32'hFFFF_FFFF);
    wr(ch_addr(0, 0), 32'h00);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_start_stop();
    t_prescale();
    t_oneshot();
    t_periodic();
    t_timebase();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R1..: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule